// File: doc/BRIEF.md
# Flash Ready Status Poller

This block tells a controller when a parallel NOR flash device has finished an internal program or erase cycle. Something else issues the command sequence. This block then reads one status location over and over through a read-request/read-data handshake to a flash bus interface. It watches one status bit per read and reports completion, a timeout, or a slow completion.

There are two completion rules.
- **Toggle mode:** the device flips data bit 6 on every read while it is busy. The block treats the operation as finished once two consecutive reads return the same bit 6 value.
- **Polling mode:** the device returns the complement of the written bit 7 while it is busy. The block treats the operation as finished once bit 7 of a read equals bit 7 of the expected byte.

In toggle mode a programmable idle gap can be placed between reads. Erase waits use a long gap, around 8 ms worth of clock cycles. Byte program waits use zero. An iteration cap bounds the whole wait. A lower threshold flags completions that took unusually many iterations.

The control state machine has four states:
- **ST_IDLE:** no wait in progress.
- **ST_REQ:** one cycle in which a read request is raised.
- **ST_RESP:** waiting for the read data.
- **ST_DELAY:** counting the idle gap.

The transitions are:
- **accept:** ST_IDLE to ST_REQ, when start_i is seen in idle.
- **issue:** ST_REQ to ST_RESP.
- **finish:** ST_RESP to ST_IDLE, on success or when the cap is reached.
- **retry_gap:** ST_RESP to ST_DELAY, in toggle mode with a non-zero gap.
- **retry_now:** ST_RESP to ST_REQ, in all other cases that do not finish.
- **gap_over:** ST_DELAY to ST_REQ, when the gap counter expires.

Top module: `flash_ready_poller`

## Requirements
- R1: While rst_n is low, and after it rises until the first start, busy_o, rd_req_o, done_o, timeout_o and slow_o are all 0.
- R2: A start_i pulse in idle captures mode_i, addr_i, expect_i and delay_i, and busy_o is 1 from the next cycle. A start_i pulse while busy_o is 1 has no effect. The same operation continues to the same outcome and read count, and rd_addr_o keeps the captured address.
- R3: Toggle mode (mode_i = 0) works as follows:
  - Bit 6 of the first read is only stored as the reference.
  - Each later read compares its bit 6 with the previous read's bit 6. Equal values finish with done_o.
  - Unequal values make the new bit 6 the reference for the next comparison.
- R4: Polling mode (mode_i = 1) finishes with done_o on the first read whose bit 7 equals expect_i bit 7. Every other bit of the read data, including bit 6, is ignored.
- R5: In toggle mode, every read after the first is preceded by delay_i idle cycles. With a read answered one cycle after its request, consecutive requests are delay_i + 2 cycles apart. A delay_i of 0 gives requests 2 cycles apart. In polling mode delay_i is ignored, and requests are always 2 cycles apart.
- R6: rd_req_o is a one-cycle pulse carrying the captured address on rd_addr_o. No new request is raised until rd_valid_i has returned data for the previous one.
- R7: Each comparison read counts one iteration. A failed comparison at iteration ITER_MAX ends the wait with timeout_o instead of done_o. Success at iteration ITER_MAX still gives done_o.
- R8: slow_o is 1 in the cycle of done_o or timeout_o exactly when the final iteration count exceeds WARN_LIM. Otherwise it is 0.
- R9: done_o and timeout_o are single-cycle pulses that never coincide. busy_o is already 0 in the cycle either pulse is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a wait (accepted only while idle) |
| mode_i | input | 1 | 0 = toggle mode, 1 = polling mode |
| addr_i | input | ADDR_W | Status location to read |
| expect_i | input | DATA_W | Byte that was programmed (bit 7 used in polling mode) |
| delay_i | input | DELAY_W | Idle cycles before each toggle-mode read after the first |
| rd_req_o | output | 1 | Read request pulse to the flash bus interface |
| rd_addr_o | output | ADDR_W | Read address |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | DATA_W | Read data |
| busy_o | output | 1 | Wait in progress |
| done_o | output | 1 | Completion pulse |
| timeout_o | output | 1 | Iteration cap reached without completion |
| slow_o | output | 1 | Final iteration count exceeded WARN_LIM |

## Verification
A scripted status source flips bit 6 for a chosen number of reads and then holds it. It also keeps bit 7 at the complement of the expected bit until a chosen read. The remaining bits carry a changing pattern, so that in polling mode the noisy bit 6 and the other bits are shown to be ignored.

Sweeping the flip length across zero, small values, the warning threshold, exactly the cap and beyond the cap separates four outcomes: plain completion, slow completion, completion on the last allowed iteration, and timeout. Gap values of 0, 1 and larger, together with a polling run given a non-zero gap, separate honoured gaps from ignored ones. A restart attempt with different mode, address and expected byte in the middle of a toggle wait shows that the first operation runs undisturbed.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DELAY = 2'd1,
        ST_REQ   = 2'd2,
        ST_RESP  = 2'd3
    } poll_state_t;

    typedef enum logic {
        MODE_TOGGLE = 1'b0,
        MODE_POLL   = 1'b1
    } poll_mode_t;

    // status bit positions decoded by the completion logic
    localparam int TOGGLE_BIT = 6;
    localparam int POLL_BIT   = 7;

endpackage

// File: rtl/poll_delay_timer.sv
module poll_delay_timer #(
    parameter int DELAY_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [DELAY_W-1:0] load_val_i,
    output logic               expired_o
);
    localparam logic [DELAY_W-1:0] ONE = DELAY_W'(1);

    logic [DELAY_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    // last cycle of the gap
    assign expired_o = (cnt_q == ONE);

endmodule

// File: rtl/poll_iter_counter.sv
module poll_iter_counter #(
    parameter int unsigned ITER_MAX = 32'h0FFF_FFFF,
    parameter int unsigned WARN_LIM = 32'h0010_0000,
    parameter int          CNT_W    = 28
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic at_cap_o,
    output logic over_warn_o
);
    localparam logic [CNT_W-1:0] CAP_M1 = CNT_W'(ITER_MAX - 1);
    localparam logic [CNT_W-1:0] WARN_T = CNT_W'(WARN_LIM);
    localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= cnt_q + ONE;
        end
    end

    // flags describe the comparison now in flight (count + 1)
    assign at_cap_o    = (cnt_q >= CAP_M1);
    assign over_warn_o = (cnt_q >= WARN_T);

endmodule

// File: rtl/poll_bit_judge.sv
module poll_bit_judge (
    input  logic is_poll_i,
    input  logic toggle_bit_i,
    input  logic poll_bit_i,
    input  logic ref_bit_i,
    input  logic expect_bit_i,
    output logic met_o
);
    always_comb begin
        if (is_poll_i) begin
            met_o = (poll_bit_i == expect_bit_i);
        end else begin
            met_o = (toggle_bit_i == ref_bit_i);
        end
    end

endmodule

// File: rtl/flash_ready_poller.sv
module flash_ready_poller
    import flash_poll_pkg::*;
#(
    parameter int          ADDR_W   = 24,
    parameter int          DATA_W   = 8,
    parameter int          DELAY_W  = 24,
    parameter int unsigned ITER_MAX = 32'h0FFF_FFFF,
    parameter int unsigned WARN_LIM = 32'h0010_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               mode_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  expect_i,
    input  logic [DELAY_W-1:0] delay_i,
    output logic               rd_req_o,
    output logic [ADDR_W-1:0]  rd_addr_o,
    input  logic               rd_valid_i,
    input  logic [DATA_W-1:0]  rd_data_i,
    output logic               busy_o,
    output logic               done_o,
    output logic               timeout_o,
    output logic               slow_o
);
    localparam int CNT_W = $clog2(ITER_MAX + 1);

    poll_state_t        state_q, state_d;
    poll_mode_t         mode_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [DELAY_W-1:0] delay_q;
    logic               exp_bit_q;
    logic               ref_q;
    logic               first_q;
    logic               done_q, tout_q, slow_q;

    logic accept, resp_ok, is_ref, met, finish_ok, finish_to;
    logic need_gap, gap_load, gap_over, at_cap, over_warn;
    logic data_unused;

    assign data_unused = ^{rd_data_i, expect_i};

    assign accept    = (state_q == ST_IDLE) && start_i;
    assign resp_ok   = (state_q == ST_RESP) && rd_valid_i;
    assign is_ref    = (mode_q == MODE_TOGGLE) && first_q;
    assign finish_ok = resp_ok && !is_ref && met;
    assign finish_to = resp_ok && !is_ref && !met && at_cap;
    assign need_gap  = (mode_q == MODE_TOGGLE) && (delay_q != '0);
    assign gap_load  = resp_ok && !finish_ok && !finish_to && need_gap;

    poll_bit_judge judge_i (
        .is_poll_i    (mode_q == MODE_POLL),
        .toggle_bit_i (rd_data_i[TOGGLE_BIT]),
        .poll_bit_i   (rd_data_i[POLL_BIT]),
        .ref_bit_i    (ref_q),
        .expect_bit_i (exp_bit_q),
        .met_o        (met)
    );

    poll_delay_timer #(.DELAY_W(DELAY_W)) gap_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (gap_load),
        .load_val_i (delay_q),
        .expired_o  (gap_over)
    );

    poll_iter_counter #(
        .ITER_MAX (ITER_MAX),
        .WARN_LIM (WARN_LIM),
        .CNT_W    (CNT_W)
    ) iter_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (accept),
        .inc_i       (resp_ok && !is_ref),
        .at_cap_o    (at_cap),
        .over_warn_o (over_warn)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_REQ;
            ST_REQ:   state_d = ST_RESP;
            ST_RESP: begin
                if (rd_valid_i) begin
                    if (finish_ok || finish_to) state_d = ST_IDLE;
                    else if (need_gap)          state_d = ST_DELAY;
                    else                        state_d = ST_REQ;
                end
            end
            ST_DELAY: if (gap_over) state_d = ST_REQ;
            default:  state_d = ST_IDLE;
        endcase
    end

    // captured operands, reference bit and result pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= MODE_TOGGLE;
            addr_q    <= '0;
            delay_q   <= '0;
            exp_bit_q <= 1'b0;
            ref_q     <= 1'b0;
            first_q   <= 1'b0;
            done_q    <= 1'b0;
            tout_q    <= 1'b0;
            slow_q    <= 1'b0;
        end else begin
            done_q <= finish_ok;
            tout_q <= finish_to;
            slow_q <= (finish_ok || finish_to) && over_warn;
            if (accept) begin
                mode_q    <= poll_mode_t'(mode_i);
                addr_q    <= addr_i;
                delay_q   <= delay_i;
                exp_bit_q <= expect_i[POLL_BIT];
                first_q   <= 1'b1;
            end
            if (resp_ok) begin
                ref_q   <= rd_data_i[TOGGLE_BIT];
                first_q <= 1'b0;
            end
        end
    end

    assign rd_req_o  = (state_q == ST_REQ);
    assign rd_addr_o = addr_q;
    assign busy_o    = (state_q != ST_IDLE);
    assign done_o    = done_q;
    assign timeout_o = tout_q;
    assign slow_o    = slow_q;

endmodule

// File: rtl/flash_ready_poller_chk.sv
module flash_ready_poller_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              rd_req_o,
    input logic              rd_valid_i,
    input logic [ADDR_W-1:0] rd_addr_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              timeout_o,
    input logic              slow_o
);
    logic pending_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
        end else if (rd_req_o) begin
            pending_q <= 1'b1;
        end else if (rd_valid_i) begin
            pending_q <= 1'b0;
        end
    end

    AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o); // R2
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(rd_addr_o)); // R2
    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |=> !rd_req_o); // R6
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> !pending_q); // R6
    AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> busy_o); // R6
    AST_SLOW_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        slow_o |-> (done_o || timeout_o)); // R8
    AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && timeout_o)); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9
    AST_TIMEOUT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |=> !timeout_o); // R9
    AST_IDLE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || timeout_o) |-> !busy_o); // R9

endmodule

bind flash_ready_poller flash_ready_poller_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .rd_req_o   (rd_req_o),
    .rd_valid_i (rd_valid_i),
    .rd_addr_o  (rd_addr_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .timeout_o  (timeout_o),
    .slow_o     (slow_o)
);

// File: tb/flash_ready_poller_tb_top.sv
module flash_ready_poller_tb_top;
    localparam int          AW = 16;
    localparam int          DW = 8;
    localparam int          LW = 8;
    localparam int unsigned IT = 20;
    localparam int unsigned WL = 8;

    // {mode, flip count, gap, expected byte}
    localparam logic [24:0] VEC [12] = '{
        {1'b0, 8'd0,  8'd0, 8'h00},
        {1'b0, 8'd3,  8'd0, 8'h00},
        {1'b0, 8'd5,  8'd3, 8'h00},
        {1'b0, 8'd9,  8'd1, 8'h00},
        {1'b0, 8'd30, 8'd0, 8'h00},
        {1'b1, 8'd0,  8'd0, 8'h80},
        {1'b1, 8'd4,  8'd5, 8'h3C},
        {1'b1, 8'd8,  8'd0, 8'hC1},
        {1'b1, 8'd7,  8'd0, 8'h7F},
        {1'b1, 8'd40, 8'd0, 8'h80},
        {1'b0, 8'd19, 8'd0, 8'h00},
        {1'b0, 8'd7,  8'd2, 8'h00}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          mode_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [DW-1:0] expect_i = '0;
    logic [LW-1:0] delay_i = '0;
    logic          rd_req_o;
    logic [AW-1:0] rd_addr_o;
    logic          rd_valid_i = 1'b0;
    logic [DW-1:0] rd_data_i = '0;
    logic          busy_o, done_o, timeout_o, slow_o;

    always #4 clk = ~clk;

    flash_ready_poller #(
        .ADDR_W(AW), .DATA_W(DW), .DELAY_W(LW), .ITER_MAX(IT), .WARN_LIM(WL)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .addr_i(addr_i), .expect_i(expect_i), .delay_i(delay_i),
        .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_valid_i(rd_valid_i),
        .rd_data_i(rd_data_i), .busy_o(busy_o), .done_o(done_o),
        .timeout_o(timeout_o), .slow_o(slow_o)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // scripted status source
    logic          m_clr = 1'b0;
    int            m_n = 0;
    logic          m_e7 = 1'b0;
    int            m_gap = 2;
    logic [AW-1:0] m_addr = '0;
    int            m_idx = 0;
    int            m_last = 0;
    logic          m_seen = 1'b0;
    int            gap_err = 0;
    int            addr_err = 0;

    function automatic logic [7:0] model_byte(int r);
        logic [7:0] b;
        b    = 8'(r * 37 + 5);
        b[6] = (r <= m_n) ? r[0] : m_n[0];
        b[7] = (r < m_n) ? ~m_e7 : m_e7;
        return b;
    endfunction

    always @(posedge clk) begin
        cyc        <= cyc + 1;
        rd_valid_i <= 1'b0;
        if (m_clr) begin
            m_idx    <= 0;
            m_seen   <= 1'b0;
            gap_err  <= 0;
            addr_err <= 0;
        end else if (rd_req_o) begin
            rd_valid_i <= 1'b1;
            rd_data_i  <= model_byte(m_idx);
            m_idx      <= m_idx + 1;
            m_last     <= cyc;
            m_seen     <= 1'b1;
            if (m_seen && (cyc - m_last != m_gap)) gap_err <= gap_err + 1;
            if (rd_addr_o != m_addr) addr_err <= addr_err + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic run_one(input logic md, input int n, input int d,
                           input logic [7:0] ex, input logic [AW-1:0] ad,
                           input bit restart);
        int  w;
        int  k;
        bit  ok;
        bit  exp_slow;
        int  exp_reads;
        bit  g_done, g_to, g_slow, g_busy;
        @(negedge clk);
        m_clr = 1'b1; m_n = n; m_e7 = ex[7]; m_addr = ad;
        m_gap = md ? 2 : d + 2;
        @(negedge clk);
        m_clr = 1'b0;
        mode_i = md; expect_i = ex; delay_i = LW'(d); addr_i = ad; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
        addr_i = ~ad;
        w = 0;
        while (!(done_o || timeout_o) && w < 3000) begin
            if (restart && w == 3) begin
                start_i = 1'b1; mode_i = ~md; expect_i = ~ex; delay_i = '0;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            w++;
        end
        start_i = 1'b0;
        if (w >= 3000) begin
            chk(1'b0, "watchdog R9 no end pulse", w, 0);
            return;
        end
        g_done = done_o; g_to = timeout_o; g_slow = slow_o; g_busy = busy_o;
        k  = n + 1;
        ok = (k <= int'(IT));
        exp_slow  = ok ? (k > int'(WL)) : (IT > WL);
        exp_reads = md ? (ok ? n + 1 : int'(IT)) : (ok ? n + 2 : int'(IT) + 1);
        chk(g_done == ok, md ? "R4 poll done" : "R3 toggle done", g_done, ok);
        chk(g_to == !ok, "R7 timeout at cap", g_to, !ok);
        chk(g_slow == exp_slow, "R8 slow flag", g_slow, exp_slow);
        chk(m_idx == exp_reads, md ? "R4 read count" : "R3 read count", m_idx, exp_reads);
        chk(gap_err == 0, "R5 request spacing", gap_err, 0);
        chk(addr_err == 0, "R6 read address", addr_err, 0);
        chk(g_busy == 1'b0, "R9 busy low at end", g_busy, 0);
        @(negedge clk);
        chk(!done_o && !timeout_o, "R9 single-cycle pulse", done_o | timeout_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk({busy_o, rd_req_o, done_o, timeout_o, slow_o} == 5'b0,
            "R1 outputs in reset", {busy_o, rd_req_o, done_o, timeout_o, slow_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({busy_o, rd_req_o, done_o, timeout_o, slow_o} == 5'b0,
            "R1 outputs after reset", {busy_o, rd_req_o, done_o, timeout_o, slow_o}, 0);

        for (int i = 0; i < 12; i++) begin
            run_one(VEC[i][24], int'(VEC[i][23:16]), int'(VEC[i][15:8]),
                    VEC[i][7:0], AW'(16'h1000 + i * 16'h0111), 1'b0);
        end

        // R2: restart with other mode, byte and address during a toggle wait
        run_one(1'b0, 3, 2, 8'h00, 16'hABCD, 1'b1);
        // R5: zero gap toggle with a long flip run, and a second restart case
        run_one(1'b0, 12, 0, 8'h00, 16'h0F0F, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule